// File: doc/BRIEF.md
# I2C Wait-State Release Controller

This block is the control logic that sits between software register strobes and the bit engine of an I2C serial interface. When the bit engine signals that a byte or acknowledge has finished, the controller enters a wait state and holds SCL low. It keeps SCL low until software performs an action that releases the wait. Each kind of release has its own follow-up:

- A data write loads a byte into the transmit shifter.
- A release strobe resumes reception without loading anything.
- A start request asks the bit engine for a repeated start.
- A stop request asks the bit engine for a stop condition.

Only the first release in a wait state is honoured. Any later strobe is dropped until the bit engine opens the next wait. Wakeup mode freezes the wait, so no release strobe can end it.

Two abort paths work at any time. A bus-exit strobe drops the current transfer and frees the bus, which recovers from a deadlock. Clearing the interface enable aborts communication. Outside a wait, and before any release, the strobes act as plain register actions.

Top module: `i2c_wait_release_ctrl`

## Requirements
- R1: At reset, scl_hold_o is 0 and sda_o is 1. scl_hold_o goes to 1 in the cycle after a wait_enter_i pulse while enabled. It stays 1 until the wait is released or aborted.
- R2: During a wait, data_wr_i ends the wait one cycle later. It loads data_i into the shifter and pulses tx_load_o for one cycle. After the load, sda_o shows data_i bit 7. Each shift_i pulse moves the next lower bit to sda_o, MSB first, and shifts a 1 in from the bottom.
- R3: During a wait, rel_set_i alone ends the wait one cycle later. It loads no data and raises no other request.
- R4: During a wait in master mode, start_set_i ends the wait and pulses restart_req_o one cycle later.
- R5: During a wait in master mode, stop_set_i ends the wait and pulses stop_req_o one cycle later.
- R6: After a wait has been released, every release strobe is ignored until the next wait_enter_i pulse. This means no load, no change on sda_o and no request.
- R7: While wake_i is 1, no release strobe ends a wait, and none produces a load or a request.
- R8: bus_exit_i at any time clears the wait and pulses bus_free_o one cycle later. It returns sda_o to 1 and forgets any earlier release.
- R9: enable_i at 0 clears the wait and sets sda_o to 1. If a wait was open or already released, it pulses abort_o once. While enable_i is 0, strobes and wait_enter_i have no effect.
- R10: When master_i is 0, start_set_i and stop_set_i are ignored. They take no part in arbitration, so a lower-priority strobe in the same cycle still wins.
- R11: Strobes in the same cycle resolve in this order: bus exit, disable, stop, start, data write, release. Exactly one follow-up pulse is issued.
- R12: With no wait open and no earlier release, strobes act as plain actions:
  - data_wr_i loads the shifter.
  - start_set_i and stop_set_i issue their requests (master only).
  - rel_set_i has no effect.
  None of these marks the wait as released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Interface enable (level) |
| master_i | input | 1 | 1 = master mode |
| wake_i | input | 1 | Wakeup mode, blocks release |
| wait_enter_i | input | 1 | Wait-entry pulse from bit engine |
| data_wr_i | input | 1 | Data shift register write strobe |
| data_i | input | DW (8) | Byte written with data_wr_i |
| rel_set_i | input | 1 | Wait-release strobe |
| start_set_i | input | 1 | Start-condition strobe |
| stop_set_i | input | 1 | Stop-condition strobe |
| bus_exit_i | input | 1 | Bus-exit (deadlock recovery) strobe |
| shift_i | input | 1 | Shift strobe from bit engine |
| scl_hold_o | output | 1 | Hold SCL low |
| sda_o | output | 1 | Current transmit bit (MSB of shifter) |
| tx_load_o | output | 1 | Transmit byte loaded pulse |
| restart_req_o | output | 1 | Repeated-start request pulse |
| stop_req_o | output | 1 | Stop request pulse |
| bus_free_o | output | 1 | Bus released pulse |
| abort_o | output | 1 | Communication aborted pulse |

## Verification
The main collision is between a release of the wait and an abort, or between several release sources, arriving in the same cycle. The vector table opens a wait and then asserts several strobes together: stop, start, write and release at once; bus exit together with stop and write; slave mode with start, stop and write. For each case the bench checks that exactly the one expected follow-up pulse appears one cycle later and that the SCL hold has dropped. A second collision, between a release strobe and a closed wait, is provoked by directed sequences: release and then write in the same wait, idle strobes before a wait, and disable during a wait. In each, the bench checks that sda_o and the request pulses stay untouched.

// File: rtl/i2c_rel_pkg.sv
package i2c_rel_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_EXIT,
    ACT_ABORT,
    ACT_STOP,
    ACT_START,
    ACT_LOAD,
    ACT_REL
  } rel_act_e;
endpackage

// File: rtl/i2c_rel_arb.sv
module i2c_rel_arb
  import i2c_rel_pkg::*;
(
  input  logic     enable_i,
  input  logic     master_i,
  input  logic     wake_i,
  input  logic     wait_q_i,
  input  logic     done_q_i,
  input  logic     bus_exit_i,
  input  logic     stop_set_i,
  input  logic     start_set_i,
  input  logic     data_wr_i,
  input  logic     rel_set_i,
  output rel_act_e act_o,
  output logic     rel_acc_o
);
  logic stop_ok, start_ok;
  assign stop_ok  = stop_set_i  & master_i;
  assign start_ok = start_set_i & master_i;

  always_comb begin
    act_o = ACT_NONE;
    if (bus_exit_i)                   act_o = ACT_EXIT;
    else if (!enable_i)               act_o = (wait_q_i | done_q_i) ? ACT_ABORT : ACT_NONE;
    else if (done_q_i)                act_o = ACT_NONE;  // one release per wait
    else if (wait_q_i && wake_i)      act_o = ACT_NONE;  // wakeup mode freezes wait
    else if (stop_ok)                 act_o = ACT_STOP;
    else if (start_ok)                act_o = ACT_START;
    else if (data_wr_i)               act_o = ACT_LOAD;
    else if (rel_set_i && wait_q_i)   act_o = ACT_REL;
  end

  assign rel_acc_o = wait_q_i &&
                     (act_o inside {ACT_STOP, ACT_START, ACT_LOAD, ACT_REL});
endmodule

// File: rtl/i2c_rel_state.sv
module i2c_rel_state
  import i2c_rel_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     enable_i,
  input  logic     wait_enter_i,
  input  rel_act_e act_i,
  input  logic     rel_acc_i,
  output logic     wait_q_o,
  output logic     done_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q_o <= 1'b0;
      done_q_o <= 1'b0;
    end else if (!enable_i || act_i == ACT_EXIT) begin
      wait_q_o <= 1'b0;
      done_q_o <= 1'b0;
    end else if (wait_enter_i) begin
      wait_q_o <= 1'b1;
      done_q_o <= 1'b0;
    end else if (rel_acc_i) begin
      wait_q_o <= 1'b0;
      done_q_o <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_tx_shift.sv
module i2c_tx_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          shift_i,
  output logic          bit_o
);
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '1;
    else if (clr_i)   sh_q <= '1;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[DW-2:0], 1'b1};
  end

  assign bit_o = sh_q[DW-1];
endmodule

// File: rtl/i2c_wait_release_ctrl.sv
module i2c_wait_release_ctrl
  import i2c_rel_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          master_i,
  input  logic          wake_i,
  input  logic          wait_enter_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          rel_set_i,
  input  logic          start_set_i,
  input  logic          stop_set_i,
  input  logic          bus_exit_i,
  input  logic          shift_i,
  output logic          scl_hold_o,
  output logic          sda_o,
  output logic          tx_load_o,
  output logic          restart_req_o,
  output logic          stop_req_o,
  output logic          bus_free_o,
  output logic          abort_o
);
  rel_act_e act;
  logic     rel_acc, wait_q, done_q, sh_clr, sh_en;

  i2c_rel_arb u_arb (
    .enable_i   (enable_i),
    .master_i   (master_i),
    .wake_i     (wake_i),
    .wait_q_i   (wait_q),
    .done_q_i   (done_q),
    .bus_exit_i (bus_exit_i),
    .stop_set_i (stop_set_i),
    .start_set_i(start_set_i),
    .data_wr_i  (data_wr_i),
    .rel_set_i  (rel_set_i),
    .act_o      (act),
    .rel_acc_o  (rel_acc)
  );

  i2c_rel_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .wait_enter_i(wait_enter_i),
    .act_i       (act),
    .rel_acc_i   (rel_acc),
    .wait_q_o    (wait_q),
    .done_q_o    (done_q)
  );

  assign sh_clr = !enable_i || act == ACT_EXIT;
  assign sh_en  = shift_i && enable_i;

  i2c_tx_shift #(.DW(DW)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sh_clr),
    .load_i (act == ACT_LOAD),
    .data_i (data_i),
    .shift_i(sh_en),
    .bit_o  (sda_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_load_o     <= 1'b0;
      restart_req_o <= 1'b0;
      stop_req_o    <= 1'b0;
      bus_free_o    <= 1'b0;
      abort_o       <= 1'b0;
    end else begin
      tx_load_o     <= act == ACT_LOAD;
      restart_req_o <= act == ACT_START;
      stop_req_o    <= act == ACT_STOP;
      bus_free_o    <= act == ACT_EXIT;
      abort_o       <= act == ACT_ABORT;
    end
  end

  assign scl_hold_o = wait_q;
endmodule

// File: rtl/i2c_wait_release_chk.sv
module i2c_wait_release_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic master_i,
  input logic wake_i,
  input logic wait_enter_i,
  input logic rel_set_i,
  input logic bus_exit_i,
  input logic data_msb_i,
  input logic scl_hold_o,
  input logic sda_o,
  input logic tx_load_o,
  input logic restart_req_o,
  input logic stop_req_o,
  input logic bus_free_o,
  input logic abort_o
);
  p_hold_after_entry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_enter_i && enable_i && !bus_exit_i |=> scl_hold_o);

  p_load_msb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |-> sda_o == $past(data_msb_i));

  p_release_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_hold_o && enable_i && !bus_exit_i && !wake_i && rel_set_i && !wait_enter_i
    |=> !scl_hold_o);

  p_wake_freezes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_hold_o && wake_i && enable_i && !bus_exit_i |=> scl_hold_o);

  p_exit_frees_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_exit_i |=> bus_free_o && !scl_hold_o && sda_o);

  p_disable_aborts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i && !bus_exit_i |=> !scl_hold_o && !tx_load_o && sda_o);

  p_slave_no_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> !restart_req_o && !stop_req_o);

  p_single_action_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_load_o, restart_req_o, stop_req_o, bus_free_o, abort_o}));
endmodule

bind i2c_wait_release_ctrl i2c_wait_release_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .master_i     (master_i),
  .wake_i       (wake_i),
  .wait_enter_i (wait_enter_i),
  .rel_set_i    (rel_set_i),
  .bus_exit_i   (bus_exit_i),
  .data_msb_i   (data_i[DW-1]),
  .scl_hold_o   (scl_hold_o),
  .sda_o        (sda_o),
  .tx_load_o    (tx_load_o),
  .restart_req_o(restart_req_o),
  .stop_req_o   (stop_req_o),
  .bus_free_o   (bus_free_o),
  .abort_o      (abort_o)
);

// File: tb/i2c_wait_release_ctrl_bench.sv
module i2c_wait_release_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b1, master_i = 1'b1, wake_i = 1'b0;
  logic       wait_enter_i = 1'b0, data_wr_i = 1'b0, rel_set_i = 1'b0;
  logic       start_set_i = 1'b0, stop_set_i = 1'b0, bus_exit_i = 1'b0, shift_i = 1'b0;
  logic [7:0] data_i = 8'h5A;
  logic       scl_hold_o, sda_o, tx_load_o, restart_req_o, stop_req_o, bus_free_o, abort_o;
  int         n_chk = 0, n_bad = 0;
  bit         finished = 1'b0;

  always #5 clk_i = ~clk_i;

  i2c_wait_release_ctrl u_i2c_wait_release_ctrl (.*);

  // [12]pre_wait [11]master [10]wake [9]exit [8]stop [7]start [6]dwr [5]rel
  // [4]hold [3]load [2]restart [1]stop_req [0]bus_free
  localparam logic [12:0] VEC [17] = '{
    13'b1100_0001_00000, // R3
    13'b1100_0010_01000, // R2
    13'b1100_0100_00100, // R4
    13'b1100_1000_00010, // R5
    13'b1000_0100_10000, // R10
    13'b1000_1000_10000, // R10
    13'b1110_0010_10000, // R7
    13'b1110_0001_10000, // R7
    13'b1100_1111_00010, // R11
    13'b1100_0111_00100, // R11
    13'b1100_0011_01000, // R11
    13'b1000_1110_01000, // R10
    13'b1101_1010_00001, // R8
    13'b0100_0010_01000, // R12
    13'b0100_0001_00000, // R12
    13'b0100_0100_00100, // R12
    13'b1111_0001_00001  // R8
  };
  localparam int VREQ [17] = '{3, 2, 4, 5, 10, 10, 7, 7, 11, 11, 11, 10, 8, 12, 12, 12, 8};

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic clear();
    wait_enter_i = 0; data_wr_i = 0; rel_set_i = 0; start_set_i = 0;
    stop_set_i = 0; bus_exit_i = 0; shift_i = 0; wake_i = 0;
  endtask

  function automatic logic [6:0] obs();
    return {scl_hold_o, tx_load_o, restart_req_o, stop_req_o, bus_free_o, abort_o, sda_o};
  endfunction

  task automatic chk(input string req, input logic [6:0] exp);
    n_chk++;
    if (obs() !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, obs(), exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    chk("R1 reset", 7'b0000001);
    rst_ni = 1'b1;
    tick();

    foreach (VEC[i]) begin
      logic [12:0] v;
      v = VEC[i];
      clear();
      bus_exit_i = 1; tick(); bus_exit_i = 0; tick();
      master_i = v[11];
      data_i   = 8'h5A;
      if (v[12]) begin
        wait_enter_i = 1; tick(); wait_enter_i = 0;
      end
      wake_i = v[10]; bus_exit_i = v[9]; stop_set_i = v[8];
      start_set_i = v[7]; data_wr_i = v[6]; rel_set_i = v[5];
      tick();
      chk($sformatf("R%0d vector %0d", VREQ[i], i), {v[4:0], 1'b0, ~v[3]});
      clear();
    end

    // R1 and R6: one release per wait
    master_i = 1; bus_exit_i = 1; tick(); bus_exit_i = 0; tick();
    wait_enter_i = 1; tick(); wait_enter_i = 0;
    chk("R1 hold set", 7'b1000001);
    tick();
    chk("R1 hold kept", 7'b1000001);
    rel_set_i = 1; tick(); rel_set_i = 0;
    chk("R3 released", 7'b0000001);
    data_i = 8'h3C; data_wr_i = 1; tick(); data_wr_i = 0;
    chk("R6 write ignored", 7'b0000001);
    start_set_i = 1; tick(); start_set_i = 0;
    chk("R6 start ignored", 7'b0000001);
    wait_enter_i = 1; tick(); wait_enter_i = 0;
    chk("R6 new wait", 7'b1000001);
    data_wr_i = 1; tick(); data_wr_i = 0;
    chk("R2 load 3C", 7'b0100000);

    // R2: MSB-first shifting, 1 fill
    shift_i = 1; tick(); tick(); shift_i = 0;
    chk("R2 bit5", 7'b0000001);
    shift_i = 1; repeat (4) tick(); shift_i = 0;
    chk("R2 bit1", 7'b0000000);
    shift_i = 1; repeat (2) tick(); shift_i = 0;
    chk("R2 fill", 7'b0000001);

    // R9: disable during wait
    wait_enter_i = 1; tick(); wait_enter_i = 0;
    enable_i = 0; tick();
    chk("R9 abort", 7'b0000011);
    data_wr_i = 1; wait_enter_i = 1; tick(); data_wr_i = 0; wait_enter_i = 0;
    chk("R9 ignored while disabled", 7'b0000001);
    enable_i = 1; tick();

    // R12: idle release does not mark the wait
    rel_set_i = 1; tick(); rel_set_i = 0;
    chk("R12 idle release", 7'b0000001);
    data_i = 8'h21; data_wr_i = 1; tick(); data_wr_i = 0;
    chk("R12 idle write", 7'b0100000);
    wait_enter_i = 1; tick(); wait_enter_i = 0;
    stop_set_i = 1; tick(); stop_set_i = 0;
    chk("R5 stop after passthrough", 7'b0001000);

    tick();
    finish_run();
  end
endmodule